// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Register

This block gives two ports, each running on its own clock, a one-word side channel in each direction that bypasses the pair of opposite-direction FIFOs between them. Each port has a chip select, an enable, a write/read select, a mailbox select and a data bus. The mailbox select chooses between two paths. When it is high, a write loads the outgoing mailbox and a read returns the incoming mailbox. When it is low, a write becomes a push strobe to the outgoing FIFO and a read becomes a pop strobe, with the incoming FIFO's output register placed on the bus.

Each mailbox carries one occupancy flag. The writing clock domain clears its "empty" view, and the reading clock domain clears its "full" view. A toggle handshake passes each event to the other domain through a chain of synchronizer flops, so that each event is counted exactly once. A write is refused while the mailbox is occupied, so a word cannot be overwritten before it is read. Each direction has its own reset.

Top module: `mbox_bypass`

## Requirements
- R1: Port A treats write/read select 1 as write and 0 as read. Port B treats 0 as write and 1 as read.
- R2: An operation takes effect at a port's rising clock edge only when its chip select is 0 and its enable is 1. Otherwise the flags and the mailbox contents are unchanged.
- R3: A write with mailbox select 1 loads the outgoing mailbox. A write with mailbox select 0 raises the port's FIFO push strobe (combinational) and leaves the mailbox alone. A read with mailbox select 0 raises the FIFO pop strobe.
- R4: During a read-selected cycle with chip select 0, the bus shows the incoming mailbox when mailbox select is 1, and the FIFO output register input when it is 0.
- R5: The writer's empty flag (1 = empty) goes to 0 right after the edge that writes the mailbox.
- R6: While the writer's empty flag is 0, further mailbox writes are ignored and the stored word is kept.
- R7: An accepted mailbox read clears the reader's full flag (1 = data present) right after that edge. The writer's empty flag returns to 1 within 4 writer clock cycles. A mailbox read while the full flag is 0 has no effect.
- R8: After a mailbox write, the reader's full flag rises within 4 reader clock cycles.
- R9: Holding a direction's reset low for at least 4 edges of both clocks sets that direction's empty flag to 1, its full flag to 0 and its stored word to 0. The other direction is left intact.
- R10: When a port is selected for writing or its chip select is 1, its output-enable is 0 and its data bus reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_ab_n | input | 1 | Synchronous active-low reset of the A-to-B direction, sampled by both clocks |
| rst_ba_n | input | 1 | Synchronous active-low reset of the B-to-A direction, sampled by both clocks |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A write/read select, 1 = write |
| a_mb | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_fifo_q | input | W | B-to-A FIFO output register |
| a_dout | output | W | Port A read data |
| a_dout_oe | output | 1 | Port A bus drive enable |
| a_fifo_we | output | 1 | A-to-B FIFO push strobe |
| a_fifo_re | output | 1 | B-to-A FIFO pop strobe |
| a_mb_empty | output | 1 | Outgoing mailbox (A to B) free, port A domain |
| a_mb_full | output | 1 | Incoming mailbox (B to A) holds data, port A domain |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B write/read select, 0 = write |
| b_mb | input | 1 | Port B mailbox select |
| b_din | input | W | Port B write data |
| b_fifo_q | input | W | A-to-B FIFO output register |
| b_dout | output | W | Port B read data |
| b_dout_oe | output | 1 | Port B bus drive enable |
| b_fifo_we | output | 1 | B-to-A FIFO push strobe |
| b_fifo_re | output | 1 | A-to-B FIFO pop strobe |
| b_mb_empty | output | 1 | Outgoing mailbox (B to A) free, port B domain |
| b_mb_full | output | 1 | Incoming mailbox (A to B) holds data, port B domain |

## Verification
The bench builds the block with its defaults: W = 36 and SYNC_STAGES = 2. The clocks run at 4 ns and 6.7 ns, so their phase relationship keeps shifting. The two-flop synchronizers make the handshake latency small enough that a 4-cycle bound on each flag can be checked directly, in both directions and for many data words. With only four control inputs per port, the bench sweeps all 16 control combinations on each port and compares the strobes, the output enable and the bus mux against values derived arithmetically from the combination.

// File: rtl/mbox_pkg.sv
// Shared types for the mailbox bypass block.
package mbox_pkg;
    // Decoded per-port operation for one clock cycle.
    typedef struct packed {
        logic oe;       // bus driven (read selected, chip selected)
        logic mb_wr;    // write request to outgoing mailbox
        logic mb_rd;    // read request from incoming mailbox
        logic fifo_we;  // push strobe to outgoing FIFO
        logic fifo_re;  // pop strobe to incoming FIFO
    } port_dec_t;
endpackage

// File: rtl/mbox_port_dec.sv
// Port operation decoder.
// Turns chip select, enable, write/read select and mailbox select into
// one-hot operation requests. WRITE_LEVEL picks the select level that
// means "write", so both port polarities share one module.
// Assumes the inputs are stable around the port's clock edge.
module mbox_port_dec #(
    parameter bit WRITE_LEVEL = 1'b1
) (
    input  logic                cs_n,
    input  logic                en,
    input  logic                wr_sel,
    input  logic                mb_sel,
    output mbox_pkg::port_dec_t dec
);
    logic is_wr;
    logic active;

    assign is_wr  = (wr_sel == WRITE_LEVEL);
    assign active = !cs_n && en;

    // Operation requests and bus enable from the qualified controls.
    assign dec.oe      = !cs_n && !is_wr;
    assign dec.mb_wr   = active &&  is_wr &&  mb_sel;
    assign dec.mb_rd   = active && !is_wr &&  mb_sel;
    assign dec.fifo_we = active &&  is_wr && !mb_sel;
    assign dec.fifo_re = active && !is_wr && !mb_sel;
endmodule

// File: rtl/mbox_sync.sv
// Multi-flop synchronizer for a single level signal.
// STAGES flops in series clocked by the destination clock, cleared
// by a synchronous active-low reset. Assumes STAGES >= 1.
module mbox_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= 1'b0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= 1'b0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
// One-direction mailbox: a data register plus a toggle handshake.
// The write domain flips wtog on each accepted write. The read domain
// flips rtog on each accepted read. Each toggle is synchronized into
// the other domain, and the flags come from comparing the toggles.
// Assumes rst_n is held low across several edges of both clocks.
module mbox_channel #(
    parameter int W      = 36,
    parameter int STAGES = 2
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    output logic         empty_w,
    output logic         full_r,
    output logic [W-1:0] data_q
);
    logic wtog, rtog;
    logic wtog_r, rtog_w;

    assign empty_w = (wtog == rtog_w);
    assign full_r  = (wtog_r != rtog);

    // Write domain: capture the word and flip the write toggle when free.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wtog   <= 1'b0;
            data_q <= '0;
        end else if (wr_req && empty_w) begin
            wtog   <= ~wtog;
            data_q <= wr_data;
        end
    end

    // Read domain: flip the read toggle when a held word is taken.
    always_ff @(posedge rclk) begin
        if (!rst_n)                rtog <= 1'b0;
        else if (rd_req && full_r) rtog <= ~rtog;
    end

    mbox_sync #(.STAGES(STAGES)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wtog), .q(wtog_r)
    );

    mbox_sync #(.STAGES(STAGES)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rtog), .q(rtog_w)
    );
endmodule

// File: rtl/mbox_bypass.sv
// Dual-clock mailbox bypass: two opposite-direction mailboxes, port
// decoders and the per-port read mux between mailbox and FIFO output.
// Port A writes with a_wr = 1; port B writes with b_wr = 0.
// Assumes the FIFOs themselves and the pad drivers sit outside.
module mbox_bypass #(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_ab_n,
    input  logic         rst_ba_n,
    input  logic         a_cs_n,
    input  logic         a_en,
    input  logic         a_wr,
    input  logic         a_mb,
    input  logic [W-1:0] a_din,
    input  logic [W-1:0] a_fifo_q,
    output logic [W-1:0] a_dout,
    output logic         a_dout_oe,
    output logic         a_fifo_we,
    output logic         a_fifo_re,
    output logic         a_mb_empty,
    output logic         a_mb_full,
    input  logic         b_cs_n,
    input  logic         b_en,
    input  logic         b_wr,
    input  logic         b_mb,
    input  logic [W-1:0] b_din,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_dout,
    output logic         b_dout_oe,
    output logic         b_fifo_we,
    output logic         b_fifo_re,
    output logic         b_mb_empty,
    output logic         b_mb_full
);
    mbox_pkg::port_dec_t dec_a, dec_b;
    logic [W-1:0]        ab_data, ba_data;

    mbox_port_dec #(.WRITE_LEVEL(1'b1)) u_dec_a (
        .cs_n(a_cs_n), .en(a_en), .wr_sel(a_wr), .mb_sel(a_mb), .dec(dec_a)
    );

    mbox_port_dec #(.WRITE_LEVEL(1'b0)) u_dec_b (
        .cs_n(b_cs_n), .en(b_en), .wr_sel(b_wr), .mb_sel(b_mb), .dec(dec_b)
    );

    mbox_channel #(.W(W), .STAGES(SYNC_STAGES)) u_ab (
        .wclk(clk_a), .rclk(clk_b), .rst_n(rst_ab_n),
        .wr_req(dec_a.mb_wr), .wr_data(a_din), .rd_req(dec_b.mb_rd),
        .empty_w(a_mb_empty), .full_r(b_mb_full), .data_q(ab_data)
    );

    mbox_channel #(.W(W), .STAGES(SYNC_STAGES)) u_ba (
        .wclk(clk_b), .rclk(clk_a), .rst_n(rst_ba_n),
        .wr_req(dec_b.mb_wr), .wr_data(b_din), .rd_req(dec_a.mb_rd),
        .empty_w(b_mb_empty), .full_r(a_mb_full), .data_q(ba_data)
    );

    // Read-path mux per port; bus held at zero while not driven.
    assign a_dout = dec_a.oe ? (a_mb ? ba_data : a_fifo_q) : '0;
    assign b_dout = dec_b.oe ? (b_mb ? ab_data : b_fifo_q) : '0;

    // FIFO strobes and drive enables straight from the decoders.
    assign a_dout_oe = dec_a.oe;
    assign b_dout_oe = dec_b.oe;
    assign a_fifo_we = dec_a.fifo_we;
    assign a_fifo_re = dec_a.fifo_re;
    assign b_fifo_we = dec_b.fifo_we;
    assign b_fifo_re = dec_b.fifo_re;
endmodule

// File: rtl/mbox_bypass_chk.sv
// Protocol checker for mbox_bypass, attached by bind below.
module mbox_bypass_chk #(
    parameter int W = 36
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         rst_ab_n,
    input logic         a_cs_n,
    input logic         a_en,
    input logic         a_wr,
    input logic         a_mb,
    input logic [W-1:0] a_dout,
    input logic         a_dout_oe,
    input logic         a_mb_empty,
    input logic         b_cs_n,
    input logic         b_en,
    input logic         b_wr,
    input logic         b_mb,
    input logic [W-1:0] b_fifo_q,
    input logic [W-1:0] b_dout,
    input logic         b_mb_full,
    input logic [W-1:0] ab_data
);
    // R5
    fill_clears_empty_chk: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
        (!a_cs_n && a_en && a_wr && a_mb && a_mb_empty) |=> !a_mb_empty);

    // R6
    no_overwrite_chk: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
        !a_mb_empty |=> $stable(ab_data));

    // R2
    deselect_idle_chk: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
        ((a_cs_n || !a_en) && a_mb_empty) |=> (a_mb_empty && $stable(ab_data)));

    // R7
    take_clears_full_chk: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
        (!b_cs_n && b_en && b_wr && b_mb && b_mb_full) |=> !b_mb_full);

    // R4
    fifo_path_chk: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
        (!b_cs_n && b_wr && !b_mb) |-> (b_dout == b_fifo_q));

    // R10
    quiet_bus_a_chk: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
        (a_cs_n || a_wr) |-> (!a_dout_oe && a_dout == '0));

    // R9
    reset_empty_chk: assert property (@(posedge clk_a)
        !rst_ab_n |=> a_mb_empty);

    // R9
    reset_full_chk: assert property (@(posedge clk_b)
        !rst_ab_n |=> !b_mb_full);
endmodule

bind mbox_bypass mbox_bypass_chk #(.W(W)) i_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_ab_n(rst_ab_n),
    .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mb(a_mb),
    .a_dout(a_dout), .a_dout_oe(a_dout_oe), .a_mb_empty(a_mb_empty),
    .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mb(b_mb),
    .b_fifo_q(b_fifo_q), .b_dout(b_dout), .b_mb_full(b_mb_full),
    .ab_data(ab_data)
);

// File: tb/test_mbox_bypass.sv
`timescale 1ns/1ps
module test_mbox_bypass;
    localparam int W = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_ab_n, rst_ba_n;
    logic a_cs_n, a_en, a_wr, a_mb;
    logic b_cs_n, b_en, b_wr, b_mb;
    logic [W-1:0] a_din, a_fifo_q, b_din, b_fifo_q;
    logic [W-1:0] a_dout, b_dout;
    logic a_dout_oe, a_fifo_we, a_fifo_re, a_mb_empty, a_mb_full;
    logic b_dout_oe, b_fifo_we, b_fifo_re, b_mb_empty, b_mb_full;
    int n_chk = 0, n_err = 0;

    always #2    clk_a = ~clk_a;
    always #3.35 clk_b = ~clk_b;

    mbox_bypass #(.W(W), .SYNC_STAGES(2)) i_mbox_bypass (.*);

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_a(); a_cs_n = 1; a_en = 0; a_wr = 0; a_mb = 0; endtask
    task automatic idle_b(); b_cs_n = 1; b_en = 0; b_wr = 1; b_mb = 0; endtask

    // One port A cycle; returns at the following falling edge.
    task automatic op_a(input logic cs_n, en, wr, mb, input logic [W-1:0] d);
        @(negedge clk_a); a_cs_n = cs_n; a_en = en; a_wr = wr; a_mb = mb; a_din = d;
        @(negedge clk_a); idle_a();
    endtask

    task automatic op_b(input logic cs_n, en, wr, mb, input logic [W-1:0] d);
        @(negedge clk_b); b_cs_n = cs_n; b_en = en; b_wr = wr; b_mb = mb; b_din = d;
        @(negedge clk_b); idle_b();
    endtask

    // Mailbox read on port B: check data before the edge, full flag after.
    task automatic take_b(input string req, input logic [W-1:0] exp);
        @(negedge clk_b); b_cs_n = 0; b_en = 1; b_wr = 1; b_mb = 1;
        #0.5 check(req, b_dout, exp);
        @(negedge clk_b); idle_b();
        check("R7 b full cleared", W'(b_mb_full), W'(0));
    endtask

    task automatic take_a(input string req, input logic [W-1:0] exp);
        @(negedge clk_a); a_cs_n = 0; a_en = 1; a_wr = 0; a_mb = 1;
        #0.5 check(req, a_dout, exp);
        @(negedge clk_a); idle_a();
        check("R7 a full cleared", W'(a_mb_full), W'(0));
    endtask

    task automatic wait_b_full(input string req);
        int k = 0;
        while (b_mb_full !== 1'b1 && k < 4) begin @(negedge clk_b); k++; end
        check(req, W'(b_mb_full), W'(1));
    endtask
    task automatic wait_a_full(input string req);
        int k = 0;
        while (a_mb_full !== 1'b1 && k < 4) begin @(negedge clk_a); k++; end
        check(req, W'(a_mb_full), W'(1));
    endtask
    task automatic wait_a_empty(input string req);
        int k = 0;
        while (a_mb_empty !== 1'b1 && k < 4) begin @(negedge clk_a); k++; end
        check(req, W'(a_mb_empty), W'(1));
    endtask
    task automatic wait_b_empty(input string req);
        int k = 0;
        while (b_mb_empty !== 1'b1 && k < 4) begin @(negedge clk_b); k++; end
        check(req, W'(b_mb_empty), W'(1));
    endtask

    task automatic do_reset(input logic ab, input logic ba);
        @(negedge clk_b);
        if (ab) rst_ab_n = 0;
        if (ba) rst_ba_n = 0;
        repeat (6) @(negedge clk_b);
        rst_ab_n = 1; rst_ba_n = 1;
        @(negedge clk_a);
    endtask

    initial begin
        #200000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_ab_n = 0; rst_ba_n = 0;
        idle_a(); idle_b();
        a_din = '0; b_din = '0; a_fifo_q = '0; b_fifo_q = '0;
        do_reset(1, 1);

        // R9 reset state
        check("R9 a empty", W'(a_mb_empty), W'(1));
        check("R9 b empty", W'(b_mb_empty), W'(1));
        check("R9 a full",  W'(a_mb_full),  W'(0));
        check("R9 b full",  W'(b_mb_full),  W'(0));

        // R1 R3 R4 R10: all 16 control combinations on port A
        for (int v = 0; v < 16; v++) begin
            logic cs_n, en, wr, mb, act, oe;
            logic [W-1:0] expd;
            cs_n = v[0]; en = v[1]; wr = v[2]; mb = v[3];
            act = !cs_n && en; oe = !cs_n && !wr;
            @(negedge clk_a);
            a_cs_n = cs_n; a_en = en; a_wr = wr; a_mb = mb;
            a_fifo_q = W'(36'hA_5000_0000 + v);
            expd = oe ? (mb ? '0 : a_fifo_q) : '0;
            #0.5;
            check("R3 a push strobe", W'(a_fifo_we), W'(act && wr && !mb));
            check("R3 a pop strobe",  W'(a_fifo_re), W'(act && !wr && !mb));
            check("R10 a drive enable", W'(a_dout_oe), W'(oe));
            check("R4 a bus", a_dout, expd);
            idle_a();
        end

        // R1 R3 R4 R10: all 16 control combinations on port B (0 = write)
        for (int v = 0; v < 16; v++) begin
            logic cs_n, en, wr, mb, act, oe;
            logic [W-1:0] expd;
            cs_n = v[0]; en = v[1]; wr = !v[2]; mb = v[3];
            act = !cs_n && en; oe = !cs_n && !wr;
            @(negedge clk_b);
            b_cs_n = cs_n; b_en = en; b_wr = v[2]; b_mb = mb;
            b_fifo_q = W'(36'h5_A000_0000 + v);
            expd = oe ? (mb ? '0 : b_fifo_q) : '0;
            #0.5;
            check("R1 b push strobe", W'(b_fifo_we), W'(act && wr && !mb));
            check("R1 b pop strobe",  W'(b_fifo_re), W'(act && !wr && !mb));
            check("R10 b drive enable", W'(b_dout_oe), W'(oe));
            check("R4 b bus", b_dout, expd);
            idle_b();
        end
        check("R2 a untouched by sweep", W'(a_mb_empty), W'(1));

        // R5 R6 R7 R8: word transfers in both directions
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] p;
            p = W'(i) * 36'h2_4924_9249 ^ 36'h9_5A5A_A5A5;
            op_a(0, 1, 1, 1, p);
            check("R5 a empty drops", W'(a_mb_empty), W'(0));
            op_a(0, 1, 1, 1, ~p);
            check("R6 a still occupied", W'(a_mb_empty), W'(0));
            wait_b_full("R8 b full rises");
            take_b("R6 b reads first word", p);
            wait_a_empty("R7 a empty returns");

            op_b(0, 1, 0, 1, ~p);
            check("R5 b empty drops", W'(b_mb_empty), W'(0));
            op_b(0, 1, 0, 1, p);
            wait_a_full("R8 a full rises");
            take_a("R6 a reads first word", ~p);
            wait_b_empty("R7 b empty returns");
        end

        // R7: read of an empty mailbox leaves no trace
        op_b(0, 1, 1, 1, '0);
        repeat (4) @(negedge clk_b);
        check("R7 empty read no full", W'(b_mb_full), W'(0));
        op_a(0, 1, 1, 1, 36'h1_2345_6789);
        wait_b_full("R7 full after write");
        take_b("R7 word after empty read", 36'h1_2345_6789);
        wait_a_empty("R7 empty again");

        // R2: deselected or disabled writes do nothing
        op_a(1, 1, 1, 1, 36'hF_FFFF_FFFF);
        op_a(0, 0, 1, 1, 36'hF_FFFF_FFFF);
        check("R2 a empty kept", W'(a_mb_empty), W'(1));
        repeat (4) @(negedge clk_b);
        check("R2 b full not set", W'(b_mb_full), W'(0));

        // R9: reset of A-to-B only
        op_a(0, 1, 1, 1, 36'h3_3333_3333);
        op_b(0, 1, 0, 1, 36'hC_CCCC_CCCC);
        wait_b_full("R9 pre b full");
        wait_a_full("R9 pre a full");
        do_reset(1, 0);
        check("R9 a empty after reset", W'(a_mb_empty), W'(1));
        check("R9 b full after reset",  W'(b_mb_full),  W'(0));
        check("R9 other direction kept", W'(a_mb_full), W'(1));
        @(negedge clk_b); b_cs_n = 0; b_wr = 1; b_mb = 1;
        #0.5 check("R9 word cleared", b_dout, '0);
        idle_b();
        take_a("R9 other word kept", 36'hC_CCCC_CCCC);
        wait_b_empty("R9 b empty returns");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule